// File: doc/BRIEF.md
# Serial Receiver with Hardware-Released Standby

This block receives asynchronous serial characters on a single input line. It uses a 16x oversampling tick from an external baud generator to find each start bit, to take three votes near the middle of every bit, and to deframe 8-bit or 9-bit characters sent least significant bit first. Each received character lands in a holding register. A read-only status byte reports whether that register is full, whether the line has gone quiet, and whether a character was overrun, noisy or badly framed.

Software can put the receiver into standby. In standby, characters that are not meant for this node are deframed but dropped, so they raise no flags. Hardware ends standby when it sees the selected wakeup condition. That condition is either a quiet line after a message or a character whose top data bit is 1. The standby bit then clears on its own, with no software write.

The register bus is byte wide, with a 2-bit address and separate read and write strobes. Address 0 is control, 1 is status, 2 is the data byte and 3 is the ninth data bit. Read data is combinational from the address. A read takes effect on the clock edge where the read strobe is high.

Top module: `uart_wake_rx`

## Requirements
- R1: Control bit 0 (address 0) switches the receiver on. At reset it is 0, and while it is 0 any activity on the line leaves the status byte at its reset value.
- R2: A frame is one low start bit, 8 data bits (9 when control bit 3 is 1) sent LSB first, and one stop bit, with 16 ticks per bit. Each bit is the majority of three samples near mid-bit. A start bit whose majority is 1 is dropped as a false start.
- R3: The status byte (address 1) has bit 7 = transmit-empty, bit 6 = transmit-done, bit 5 = receive-full, bit 4 = line-idle, bit 3 = overrun, bit 2 = noise, bit 1 = framing and bit 0 = parity. Bits 7 and 6 read as 1, so the reset value is 0xC0.
- R4: The status byte is read-only. A write to address 1 changes no flag.
- R5: Reading the status byte and then the data byte (address 2) clears the flags that were set when the status byte was read. A data read with no status read before it clears nothing.
- R6: If a character completes while receive-full is 1, overrun is set and the held data keeps the earlier character.
- R7: A stop bit whose majority is 0 sets the framing flag together with receive-full.
- R8: If the three samples of any bit in a character disagree, the noise flag is set with that character, and the data still follows the majority votes.
- R9: In 9-bit mode, address 2 returns data bits 7..0 and bit 0 of address 3 returns data bit 8.
- R10: Line-idle is set once when the line has stayed high for 10 bit times (11 in 9-bit mode), counted from the stop bit of a received character. It is not set before that time.
- R11: Writing control bit 1 to 1 puts the receiver into standby. In standby, a character that does not meet the wakeup condition sets no flag.
- R12: With control bit 2 = 1 (address-mark wakeup), a character whose top data bit is 1 clears the standby bit and is received normally. A quiet line does not end standby in this mode.
- R13: With control bit 2 = 0 (idle-line wakeup), a quiet line after a character clears the standby bit without setting line-idle, and the next character is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxIn | input | 1 | Serial receive line, idle high |
| baudTick | input | 1 | One-cycle pulse at 16x the bit rate |
| addr | input | 2 | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (side effects on this edge) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the current address |

## Verification
Plain characters with different bit patterns check the LSB-first deframing. The same character then goes out with a 0 stop bit, and again with a glitch on one mid-bit sample, which separates the framing and noise paths from plain reception. Back-to-back characters and a short low pulse separate overrun from a false start. In standby, the same characters are sent with the top bit clear and then set, in each wakeup mode, to show which mode reacts to the address mark and which one reacts to a quiet line.

// File: rtl/uart_wake_rx_pkg.sv
package uart_wake_rx_pkg;

  // control register fields
  typedef struct packed {
    logic nineBit;
    logic wakeSel;
    logic standby;
    logic rxOn;
  } rxCfgT;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic sample;
    logic decide;
    logic clrNoise;
    logic shiftIn;
    logic loadHold;
    logic idleRun;
    logic idleClr;
  } rxStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rxStateT;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_STAT  = 2'd1;
  localparam logic [1:0] ADDR_DATA  = 2'd2;
  localparam logic [1:0] ADDR_NINTH = 2'd3;

endpackage

// File: rtl/uart_wake_rx_dp.sv
module uart_wake_rx_dp
  import uart_wake_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  logic                 nineBit,
  input  rxStrobeT             strb,
  output logic                 rxSync,
  output logic                 voteBit,
  output logic                 charNoise,
  output logic                 msbBit,
  output logic                 idleHit,
  output logic [DATA_BITS-1:0] holdData,
  output logic                 holdNinth
);

  localparam int SHIFT_W    = DATA_BITS + 1;
  localparam int IDLE_SHORT = (DATA_BITS + 2) * OVERSAMPLE;
  localparam int IDLE_LONG  = (DATA_BITS + 3) * OVERSAMPLE;
  localparam int IDLE_W     = $clog2(IDLE_LONG + 1);

  // input synchronizer, resets to the idle level
  logic [SYNC_STAGES-1:0] syncQ;
  generate
    if (SYNC_STAGES < 2) begin : g_bad_sync
      initial $error("SYNC_STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxIn};
  end
  assign rxSync = syncQ[SYNC_STAGES-1];

  // three mid-bit samples and their vote
  logic [2:0] sampQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            sampQ <= '1;
    else if (strb.sample) sampQ <= {sampQ[1:0], rxSync};
  end

  logic noisyBit;
  assign voteBit  = (sampQ[0] & sampQ[1]) | (sampQ[0] & sampQ[2]) | (sampQ[1] & sampQ[2]);
  assign noisyBit = (|sampQ) & ~(&sampQ);

  // noise accumulated across the whole character
  logic noiseAcc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              noiseAcc <= 1'b0;
    else if (strb.clrNoise) noiseAcc <= noisyBit;
    else if (strb.decide)   noiseAcc <= noiseAcc | noisyBit;
  end
  assign charNoise = noiseAcc | noisyBit;

  // data shifter, LSB arrives first
  logic [SHIFT_W-1:0] shiftQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftQ <= '0;
    else if (strb.shiftIn) shiftQ <= {voteBit, shiftQ[SHIFT_W-1:1]};
  end
  assign msbBit = shiftQ[SHIFT_W-1];

  // holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData  <= '0;
      holdNinth <= 1'b0;
    end else if (strb.loadHold) begin
      if (nineBit) begin
        holdData  <= shiftQ[DATA_BITS-1:0];
        holdNinth <= shiftQ[DATA_BITS];
      end else begin
        holdData  <= shiftQ[SHIFT_W-1:1];
        holdNinth <= 1'b0;
      end
    end
  end

  // quiet-line counter, saturates at the threshold
  logic [IDLE_W-1:0] idleCnt;
  logic [IDLE_W-1:0] idleThr;
  assign idleThr = nineBit ? IDLE_W'(IDLE_LONG) : IDLE_W'(IDLE_SHORT);
  assign idleHit = strb.idleRun && (idleCnt == idleThr - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   idleCnt <= '0;
    else if (strb.idleClr)                       idleCnt <= '0;
    else if (strb.idleRun && idleCnt != idleThr) idleCnt <= idleCnt + 1'b1;
  end

endmodule

// File: rtl/uart_wake_rx_ctrl.sv
module uart_wake_rx_ctrl
  import uart_wake_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 baudTick,
  input  logic [1:0]           addr,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [DATA_BITS-1:0] wrData,
  output logic [DATA_BITS-1:0] rdData,
  input  logic                 rxSync,
  input  logic                 voteBit,
  input  logic                 charNoise,
  input  logic                 msbBit,
  input  logic                 idleHit,
  input  logic [DATA_BITS-1:0] holdData,
  input  logic                 holdNinth,
  output rxCfgT                cfg,
  output rxStrobeT             strb
);

  localparam int CNT_W      = $clog2(OVERSAMPLE);
  localparam int MID        = OVERSAMPLE / 2;
  localparam int SAMP_FIRST = MID - 1;
  localparam int SAMP_LAST  = MID + 1;
  localparam int DECIDE     = MID + 2;
  localparam int BIT_W      = $clog2(DATA_BITS + 1);
  localparam int FLAG_N     = 5;

  // flag vector order matches status bits 5..1
  localparam int F_FULL = 4;
  localparam int F_IDLE = 3;
  localparam int F_OVR  = 2;
  localparam int F_NSE  = 1;
  localparam int F_FRM  = 0;

  rxStateT          state;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [BIT_W-1:0] lastBit;
  logic             inFrame;
  logic             charDone;

  assign lastBit = cfg.nineBit ? BIT_W'(DATA_BITS) : BIT_W'(DATA_BITS - 1);
  assign inFrame = cfg.rxOn && (state != ST_IDLE);

  // frame timing strobes
  always_comb begin
    strb.sample   = baudTick && inFrame &&
                    (tickCnt >= CNT_W'(SAMP_FIRST)) && (tickCnt <= CNT_W'(SAMP_LAST));
    strb.decide   = baudTick && inFrame && (tickCnt == CNT_W'(DECIDE));
    strb.clrNoise = strb.decide && (state == ST_START);
    strb.shiftIn  = strb.decide && (state == ST_DATA);
    strb.idleRun  = baudTick && cfg.rxOn && (state == ST_IDLE) && rxSync;
    strb.idleClr  = !cfg.rxOn || (state != ST_IDLE) || (baudTick && !rxSync);
    strb.loadHold = 1'b0;
  end
  assign charDone = strb.decide && (state == ST_STOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (!cfg.rxOn) begin
      state   <= ST_IDLE;
    end else if (baudTick) begin
      if (state == ST_IDLE) begin
        if (!rxSync) begin
          state   <= ST_START;
          tickCnt <= CNT_W'(1);
        end
      end else begin
        tickCnt <= tickCnt + 1'b1;
        if (tickCnt == CNT_W'(DECIDE)) begin
          unique case (state)
            ST_START: begin
              if (voteBit) state <= ST_IDLE;
              else begin
                state  <= ST_DATA;
                bitCnt <= '0;
              end
            end
            ST_DATA: begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == lastBit) state <= ST_STOP;
            end
            ST_STOP: state <= ST_IDLE;
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // wakeup and acceptance
  logic flagsFull;
  logic wakeAddr;
  logic accept;
  logic idleArm;
  logic idleEvent;
  logic standbyClr;
  logic loadNow;

  assign wakeAddr   = cfg.standby && cfg.wakeSel && msbBit;
  assign accept     = charDone && (!cfg.standby || wakeAddr);
  assign loadNow    = accept && !flagsFull;
  assign idleEvent  = idleHit && idleArm;
  assign standbyClr = (idleEvent && cfg.standby && !cfg.wakeSel) || (charDone && wakeAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               idleArm <= 1'b0;
    else if (!cfg.rxOn)      idleArm <= 1'b0;
    else if (charDone)       idleArm <= 1'b1;
    else if (idleHit)        idleArm <= 1'b0;
  end

  // control register
  logic ctrlWr;
  logic [DATA_BITS-5:0] unusedWr;
  assign ctrlWr   = wrEn && (addr == ADDR_CTRL);
  assign unusedWr = wrData[DATA_BITS-1:4];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfg <= '0;
    else if (ctrlWr) begin
      cfg.rxOn    <= wrData[0];
      cfg.standby <= wrData[1];
      cfg.wakeSel <= wrData[2];
      cfg.nineBit <= wrData[3];
    end else if (standbyClr) begin
      cfg.standby <= 1'b0;
    end
  end

  // status flags and the read-then-read clear sequence
  logic [FLAG_N-1:0] flagsQ;
  logic [FLAG_N-1:0] armQ;
  logic [FLAG_N-1:0] setVec;
  logic [FLAG_N-1:0] clrVec;
  logic              statRd;
  logic              dataRd;

  assign statRd    = rdEn && (addr == ADDR_STAT);
  assign dataRd    = rdEn && (addr == ADDR_DATA);
  assign flagsFull = flagsQ[F_FULL];
  assign clrVec    = dataRd ? armQ : '0;

  always_comb begin
    setVec         = '0;
    setVec[F_FULL] = loadNow;
    setVec[F_OVR]  = accept && flagsFull;
    setVec[F_FRM]  = loadNow && !voteBit;
    setVec[F_NSE]  = loadNow && charNoise;
    setVec[F_IDLE] = idleEvent && !cfg.standby;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
      armQ   <= '0;
    end else begin
      flagsQ <= (flagsQ & ~clrVec) | setVec;
      if (statRd)      armQ <= flagsQ;
      else if (dataRd) armQ <= '0;
    end
  end

  // load strobe to the datapath
  rxStrobeT strbOut;
  always_comb begin
    strbOut          = strb;
    strbOut.loadHold = loadNow;
  end

  // read mux
  logic [DATA_BITS-1:0] statusWord;
  assign statusWord = DATA_BITS'({2'b11, flagsQ, 1'b0});

  always_comb begin
    unique case (addr)
      ADDR_CTRL:  rdData = DATA_BITS'({cfg.nineBit, cfg.wakeSel, cfg.standby, cfg.rxOn});
      ADDR_STAT:  rdData = statusWord;
      ADDR_DATA:  rdData = holdData;
      ADDR_NINTH: rdData = DATA_BITS'(holdNinth);
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
  import uart_wake_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  logic                 baudTick,
  input  logic [1:0]           addr,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [DATA_BITS-1:0] wrData,
  output logic [DATA_BITS-1:0] rdData
);

  rxCfgT                cfg;
  rxStrobeT             strbCtl;
  rxStrobeT             strb;
  logic                 rxSync;
  logic                 voteBit;
  logic                 charNoise;
  logic                 msbBit;
  logic                 idleHit;
  logic [DATA_BITS-1:0] holdData;
  logic                 holdNinth;

  uart_wake_rx_ctrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .DATA_BITS (DATA_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .baudTick (baudTick),
    .addr     (addr),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .wrData   (wrData),
    .rdData   (rdData),
    .rxSync   (rxSync),
    .voteBit  (voteBit),
    .charNoise(charNoise),
    .msbBit   (msbBit),
    .idleHit  (idleHit),
    .holdData (holdData),
    .holdNinth(holdNinth),
    .cfg      (cfg),
    .strb     (strbCtl)
  );

  // the load strobe is produced after acceptance in the control block
  assign strb = {strbCtl.sample, strbCtl.decide, strbCtl.clrNoise, strbCtl.shiftIn,
                 u_ctrl.loadNow, strbCtl.idleRun, strbCtl.idleClr};

  uart_wake_rx_dp #(
    .OVERSAMPLE (OVERSAMPLE),
    .DATA_BITS  (DATA_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rxIn     (rxIn),
    .nineBit  (cfg.nineBit),
    .strb     (strb),
    .rxSync   (rxSync),
    .voteBit  (voteBit),
    .charNoise(charNoise),
    .msbBit   (msbBit),
    .idleHit  (idleHit),
    .holdData (holdData),
    .holdNinth(holdNinth)
  );

endmodule

// File: rtl/uart_wake_rx_chk.sv
module uart_wake_rx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] addr,
  input logic       rxOn,
  input logic       standby,
  input logic       wakeSel,
  input logic       loadHold,
  input logic       decide,
  input logic       msbBit,
  input logic       idleHit
);

  // R1: a switched-off receiver never reports a quiet line
  a_r1_off_no_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rxOn |=> !idleHit);

  // R11: idle-line standby never loads a character
  a_r11_standby_no_load: assert property (@(posedge clk) disable iff (!rstN)
    (standby && !wakeSel) |-> !loadHold);

  // R12: a load during address-mark standby carries the mark
  a_r12_wake_needs_mark: assert property (@(posedge clk) disable iff (!rstN)
    (standby && wakeSel && loadHold) |-> msbBit);

  // R13: standby ends only by software, quiet line or a finished bit decision
  a_r13_standby_exit_cause: assert property (@(posedge clk) disable iff (!rstN)
    (!standby && $past(standby) && !($past(wrEn) && $past(addr) == 2'd0))
      |-> ($past(idleHit) || $past(decide)));

  // R6: one load per character
  a_r6_single_load: assert property (@(posedge clk) disable iff (!rstN)
    loadHold |=> !loadHold);

endmodule

bind uart_wake_rx uart_wake_rx_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .rxOn    (cfg.rxOn),
  .standby (cfg.standby),
  .wakeSel (cfg.wakeSel),
  .loadHold(strb.loadHold),
  .decide  (strb.decide),
  .msbBit  (msbBit),
  .idleHit (idleHit)
);

// File: tb/uart_wake_rx_tb.sv
module uart_wake_rx_tb;

  localparam int BIT_CLKS = 32;  // 16 ticks, one tick every 2 clocks

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxIn = 1'b1;
  logic       baudTick = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_wake_rx u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .rxIn    (rxIn),
    .baudTick(baudTick),
    .addr    (addr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .wrData  (wrData),
    .rdData  (rdData)
  );

  initial begin
    forever begin
      @(negedge clk);
      baudTick = ~baudTick;
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitBits(input int n);
    repeat (n * BIT_CLKS) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [8:0] val, input int nbits,
                           input logic stopV, input int glitchBit);
    rxIn = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      for (int c = 0; c < BIT_CLKS; c++) begin
        rxIn = (i == glitchBit && c >= 16 && c < 18) ? ~val[i] : val[i];
        @(negedge clk);
      end
    end
    rxIn = stopV;
    repeat (BIT_CLKS) @(negedge clk);
    rxIn = 1'b1;
  endtask

  task automatic drain();
    logic [7:0] d;
    waitBits(13);
    busRead(2'd1, d);
    busRead(2'd2, d);
  endtask

  task automatic testReset();
    logic [7:0] d;
    busRead(2'd1, d); chk("R3 reset status", d, 8'hC0);
    busRead(2'd0, d); chk("R1 reset control off", d, 8'h00);
    busRead(2'd2, d); chk("R3 reset data", d, 8'h00);
  endtask

  task automatic testOff();
    logic [7:0] d;
    sendFrame(9'h055, 8, 1'b1, -1);
    waitBits(13);
    busRead(2'd1, d); chk("R1 receiver off ignores line", d, 8'hC0);
  endtask

  task automatic testBasic();
    logic [7:0] d;
    sendFrame(9'h0A5, 8, 1'b1, -1);
    busRead(2'd2, d); chk("R2 data A5", d, 8'hA5);
    busRead(2'd1, d); chk("R5 data read alone keeps full", d, 8'hE0);
    busRead(2'd2, d);
    busRead(2'd1, d); chk("R5 sequence clears full", d, 8'hC0);
    drain();
  endtask

  task automatic testIdle();
    logic [7:0] d;
    sendFrame(9'h00F, 8, 1'b1, -1);
    waitBits(2);
    busRead(2'd1, d); chk("R10 idle not early", d, 8'hE0);
    waitBits(10);
    busRead(2'd1, d); chk("R10 idle set", d, 8'hF0);
    busRead(2'd2, d); chk("R2 data 0F", d, 8'h0F);
    busRead(2'd1, d); chk("R5 idle and full cleared", d, 8'hC0);
    waitBits(13);
    busRead(2'd1, d); chk("R10 idle set only once", d, 8'hC0);
  endtask

  task automatic testReadOnly();
    logic [7:0] d;
    sendFrame(9'h03C, 8, 1'b1, -1);
    busWrite(2'd1, 8'h00);
    busWrite(2'd1, 8'hFF);
    busRead(2'd1, d); chk("R4 status write ignored", d, 8'hE0);
    drain();
  endtask

  task automatic testOverrun();
    logic [7:0] d;
    sendFrame(9'h011, 8, 1'b1, -1);
    sendFrame(9'h022, 8, 1'b1, -1);
    busRead(2'd1, d); chk("R6 overrun status", d, 8'hE8);
    busRead(2'd2, d); chk("R6 first data kept", d, 8'h11);
    busRead(2'd1, d); chk("R5 overrun cleared", d, 8'hC0);
    drain();
  endtask

  task automatic testFraming();
    logic [7:0] d;
    sendFrame(9'h05A, 8, 1'b0, -1);
    busRead(2'd1, d); chk("R7 framing status", d, 8'hE2);
    busRead(2'd2, d); chk("R7 framing data", d, 8'h5A);
    drain();
  endtask

  task automatic testNoise();
    logic [7:0] d;
    sendFrame(9'h069, 8, 1'b1, 3);
    busRead(2'd1, d); chk("R8 noise status", d, 8'hE4);
    busRead(2'd2, d); chk("R8 majority data", d, 8'h69);
    drain();
  endtask

  task automatic testFalseStart();
    logic [7:0] d;
    rxIn = 1'b0;
    repeat (8) @(negedge clk);
    rxIn = 1'b1;
    waitBits(3);
    busRead(2'd1, d); chk("R2 false start dropped", d, 8'hC0);
  endtask

  task automatic testNine();
    logic [7:0] d;
    busWrite(2'd0, 8'h09);
    sendFrame(9'h13C, 9, 1'b1, -1);
    busRead(2'd1, d); chk("R9 nine-bit full", d, 8'hE0);
    busRead(2'd2, d); chk("R9 low byte", d, 8'h3C);
    busRead(2'd3, d); chk("R9 ninth bit set", d, 8'h01);
    drain();
    sendFrame(9'h0C3, 9, 1'b1, -1);
    busRead(2'd3, d); chk("R9 ninth bit clear", d, 8'h00);
    busRead(2'd1, d);
    busRead(2'd2, d); chk("R9 low byte C3", d, 8'hC3);
    drain();
    busWrite(2'd0, 8'h01);
  endtask

  task automatic testAddrWake();
    logic [7:0] d;
    busWrite(2'd0, 8'h07);
    sendFrame(9'h012, 8, 1'b1, -1);
    busRead(2'd1, d); chk("R11 unmarked char dropped", d, 8'hC0);
    busRead(2'd0, d); chk("R11 still in standby", d, 8'h07);
    waitBits(13);
    busRead(2'd0, d); chk("R12 quiet line no wake", d, 8'h07);
    busRead(2'd1, d); chk("R11 no idle flag in standby", d, 8'hC0);
    sendFrame(9'h085, 8, 1'b1, -1);
    busRead(2'd0, d); chk("R12 mark clears standby", d, 8'h05);
    busRead(2'd1, d); chk("R12 marked char flagged", d, 8'hE0);
    busRead(2'd2, d); chk("R12 marked char data", d, 8'h85);
    drain();
    busWrite(2'd0, 8'h01);
  endtask

  task automatic testIdleWake();
    logic [7:0] d;
    busWrite(2'd0, 8'h03);
    sendFrame(9'h090, 8, 1'b1, -1);
    busRead(2'd1, d); chk("R11 char dropped in idle mode", d, 8'hC0);
    busRead(2'd0, d); chk("R13 mark does not wake", d, 8'h03);
    waitBits(13);
    busRead(2'd0, d); chk("R13 quiet line wakes", d, 8'h01);
    busRead(2'd1, d); chk("R13 no idle flag on wake", d, 8'hC0);
    sendFrame(9'h03C, 8, 1'b1, -1);
    busRead(2'd1, d); chk("R13 next char flagged", d, 8'hE0);
    busRead(2'd2, d); chk("R13 next char data", d, 8'h3C);
    drain();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testOff();
    busWrite(2'd0, 8'h01);
    waitBits(2);
    testBasic();
    testIdle();
    testReadOnly();
    testOverrun();
    testFraming();
    testNoise();
    testFalseStart();
    testNine();
    testAddrWake();
    testIdleWake();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog got=hung exp=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule